// File: doc/BRIEF.md
# Clock Monitor Control with Frequency Meter

This block controls a clock-monitoring subsystem. Software reaches it through a small word-addressed register port. A control word selects one of three oscillator inputs for a frequency measurement and arms the measurement with a self-clearing start flag. The same word also sets a power-of-two divider that produces a slowed-down copy of the fast RC oscillator, and it drives an enable line for the PLL clock monitor. The divided RC clock leaves the block as the reference against which the fast crystal oscillator is checked elsewhere.

A measurement runs for a fixed window of bus-clock cycles, given by a parameter. Each oscillator input is brought into the bus-clock domain through a flop chain, and its rising edges become single-cycle pulses. The pulses of the selected source are counted over the window. The count is then stored in a read-only result word, and the start flag drops in the same cycle. To be counted exactly, a source must run slower than half the bus clock.

Top module: `clkmon_ctrl`

## Requirements
- R1: After reset, the control word at address 0x0 reads 0x0000_0300: the divide field [9:8] is 3, and the start flag [0], the source field [5:4] and the monitor-enable bit [12] are all 0. The result word at address 0x4 reads 0.
- R2: Writing the control word with bit 0 at 1 sets the start flag. Writing bit 0 at 0 leaves the flag unchanged. Reset clears the flag, including in the middle of a measurement.
- R3: Once set, the start flag reads 1 for exactly WINDOW bus-clock cycles and then reads 0. In the first cycle it reads 0, the new result is already readable at address 0x4.
- R4: The result equals the number of rising edges of the selected source within the window. A source that is periodic with period P bus cycles, where WINDOW is a multiple of P, gives WINDOW/P.
- R5: The source field [5:4] selects 0 = fast RC, 1 = slow RC, 2 = slow crystal and 3 = fast RC.
- R6: ref_clk_out is the fast RC clock divided by 2 to the power of the divide field [9:8]. A field value of 0 passes the clock through undivided.
- R7: While the start flag is 1, writes leave the source field unchanged. In the same writes, the divide field and the monitor-enable bit still take the written values.
- R8: Bit [12] of the control word drives pll_mon_en directly.
- R9: Bits outside the defined fields read 0 and ignore writes. Writes to address 0x4 have no effect, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and reference-window clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| fast_rc_clk | input | 1 | Fast internal RC oscillator |
| slow_rc_clk | input | 1 | Slow internal RC oscillator |
| slow_xtal_clk | input | 1 | Slow crystal oscillator |
| ref_clk_out | output | 1 | Divided fast RC clock |
| pll_mon_en | output | 1 | PLL clock monitor enable |

## Verification
The bench generates the three sources with distinct periods of 4, 6 and 10 bus cycles, and the window is a common multiple of all three. A measurement is run for each of the four select codes. Because the counts differ (30, 20 and 12), any wrong route through the select multiplexer shows up, and code 3 shows up if it fails to return to the fast RC clock. Every divide setting is swept by counting ref_clk_out edges over a fixed span; the expected halving from one setting to the next exposes an off-by-one tap. Control words are also written while a measurement is in progress, and these separate the held source field from the freely written fields.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
    localparam int DATA_W    = 32;
    localparam int SEL_W     = 2;
    localparam int DIV_W     = 2;
    localparam int START_BIT = 0;
    localparam int SEL_LSB   = 4;
    localparam int DIV_LSB   = 8;
    localparam int MON_BIT   = 12;
    localparam int N_SRC     = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_FAST_RC  = 2'b00,
        SRC_SLOW_RC  = 2'b01,
        SRC_SLOW_XT  = 2'b10,
        SRC_FAST_ALT = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic             start;
        src_sel_e         sel;
        logic [DIV_W-1:0] div;
        logic             mon_en;
    } ctrl_t;
endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R4: a synchronized edge yields a pulse of exactly one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/clkmon_rc_divider.sv
module clkmon_rc_divider
    import clkmon_pkg::*;
(
    input  logic             fast_rc_clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             ref_clk_out
);
    localparam int TAPS = (1 << DIV_W) - 1;

    logic [TAPS-1:0] cnt_d, cnt_q;
    logic [TAPS:0]   taps;

    always_comb begin
        cnt_d = cnt_q + TAPS'(1);
    end

    always_ff @(posedge fast_rc_clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign taps        = {cnt_q, fast_rc_clk};
    assign ref_clk_out = taps[div];
endmodule

// File: rtl/clkmon_freq_meter.sv
module clkmon_freq_meter #(
    parameter int WINDOW = 120
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic                        rise,
    output logic                        done,
    output logic [$clog2(WINDOW+1)-1:0] result
);
    localparam int WIN_W = $clog2(WINDOW);
    localparam int CNT_W = $clog2(WINDOW+1);
    localparam logic [WIN_W-1:0] LAST = WIN_W'(WINDOW - 1);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] res;
    } meter_t;

    meter_t m_d, m_q;

    always_comb begin
        m_d  = m_q;
        done = 1'b0;
        if (run) begin
            if (m_q.win == LAST) begin
                done    = 1'b1;
                m_d.res = m_q.cnt + CNT_W'(rise);
                m_d.win = '0;
                m_d.cnt = '0;
            end else begin
                m_d.win = m_q.win + WIN_W'(1);
                m_d.cnt = m_q.cnt + CNT_W'(rise);
            end
        end else begin
            m_d.win = '0;
            m_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign result = m_q.res;

    // R3: the window counter never passes its last cycle
    a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.win <= LAST);
    // R4: at most one edge per elapsed window cycle
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(m_q.win) >= m_q.cnt);
endmodule

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl
    import clkmon_pkg::*;
#(
    parameter int WINDOW      = 120,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              fast_rc_clk,
    input  logic              slow_rc_clk,
    input  logic              slow_xtal_clk,
    output logic              ref_clk_out,
    output logic              pll_mon_en
);
    localparam int CNT_W = $clog2(WINDOW+1);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] RES_ADDR  = ADDR_W'(4);

    ctrl_t ctrl_d, ctrl_q;
    logic [N_SRC-1:0] src_async, src_rise;
    logic             sel_rise, meter_done, ctrl_wr;
    logic [CNT_W-1:0] meter_res;
    logic [31:0]      ctrl_word;

    assign src_async = {slow_xtal_clk, slow_rc_clk, fast_rc_clk};

    for (genvar g = 0; g < N_SRC; g++) begin : g_sync
        clkmon_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (src_async[g]),
            .rise     (src_rise[g])
        );
    end

    always_comb begin
        case (ctrl_q.sel)
            SRC_SLOW_RC: sel_rise = src_rise[1];
            SRC_SLOW_XT: sel_rise = src_rise[2];
            default:     sel_rise = src_rise[0];
        endcase
    end

    clkmon_freq_meter #(.WINDOW(WINDOW)) meter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_q.start),
        .rise   (sel_rise),
        .done   (meter_done),
        .result (meter_res)
    );

    clkmon_rc_divider div_i (
        .fast_rc_clk (fast_rc_clk),
        .rst_n       (rst_n),
        .div         (ctrl_q.div),
        .ref_clk_out (ref_clk_out)
    );

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            if (bus_wdata[START_BIT]) ctrl_d.start = 1'b1;
            if (!ctrl_q.start)
                ctrl_d.sel = src_sel_e'(bus_wdata[SEL_LSB +: SEL_W]);
            ctrl_d.div    = bus_wdata[DIV_LSB +: DIV_W];
            ctrl_d.mon_en = bus_wdata[MON_BIT];
        end
        if (meter_done) ctrl_d.start = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q        <= '0;
            ctrl_q.div    <= '1;
        end else begin
            ctrl_q        <= ctrl_d;
        end
    end

    always_comb begin
        ctrl_word                       = '0;
        ctrl_word[START_BIT]            = ctrl_q.start;
        ctrl_word[SEL_LSB +: SEL_W]     = ctrl_q.sel;
        ctrl_word[DIV_LSB +: DIV_W]     = ctrl_q.div;
        ctrl_word[MON_BIT]              = ctrl_q.mon_en;
        case (bus_addr)
            CTRL_ADDR: bus_rdata = ctrl_word;
            RES_ADDR:  bus_rdata = 32'(meter_res);
            default:   bus_rdata = '0;
        endcase
    end

    assign pll_mon_en = ctrl_q.mon_en;

    // R2: the start flag only rises after a software write of bit 0
    a_r2_sw_start_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.start) |-> $past(ctrl_wr && bus_wdata[START_BIT]));
    // R3: completion of the window drops the start flag
    a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        meter_done |=> !ctrl_q.start);
    // R7: source select holds still across a running measurement
    a_r7_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.start && $past(ctrl_q.start)) |-> $stable(ctrl_q.sel));
    // R8: monitor enable output follows the stored bit
    a_r8_mon_pin: assert property (@(posedge clk) disable iff (!rst_n)
        pll_mon_en == ctrl_word[MON_BIT]);
endmodule

// File: tb/clkmon_ctrl_tb.sv
module clkmon_ctrl_tb_top;
    localparam int WIN = 120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fast_rc_clk = 1'b0, slow_rc_clk = 1'b0, slow_xtal_clk = 1'b0;
    logic        ref_clk_out, pll_mon_en;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    clkmon_ctrl #(.WINDOW(WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fast_rc_clk(fast_rc_clk), .slow_rc_clk(slow_rc_clk),
        .slow_xtal_clk(slow_xtal_clk), .ref_clk_out(ref_clk_out),
        .pll_mon_en(pll_mon_en)
    );

    always #5 clk = ~clk;

    // sources toggle on falling bus-clock edges: periods 4, 6 and 10 cycles
    int cf = 0, cs = 0, cx = 0;
    always @(negedge clk) begin
        cf = cf + 1; cs = cs + 1; cx = cx + 1;
        if (cf == 2) begin cf = 0; fast_rc_clk <= ~fast_rc_clk; end
        if (cs == 3) begin cs = 0; slow_rc_clk <= ~slow_rc_clk; end
        if (cx == 5) begin cx = 0; slow_xtal_clk <= ~slow_xtal_clk; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] v;
        n = 0;
        rd(4'h0, v);
        while (v[0] && n < 10 * WIN) begin
            n++;
            @(posedge clk); #1;
            rd(4'h0, v);
        end
    endtask

    function automatic logic [31:0] word(input int sel, input int dv, input bit mon, input bit st);
        return (32'(mon) << 12) | (32'(dv) << 8) | (32'(sel) << 4) | 32'(st);
    endfunction

    initial begin
        logic [31:0] v;
        int n;
        int exp_cnt [4] = '{30, 20, 12, 30};
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, v); chk("R1 ctrl reset", v, 32'h0000_0300);
        rd(4'h4, v); chk("R1 result reset", v, 32'h0);
        chk("R8 enable at reset", 32'(pll_mon_en), 32'h0);

        // R9 undefined bits, R8 enable pin
        wr(4'h0, 32'hFFFF_FFFE);
        rd(4'h0, v); chk("R9 all-ones write", v, 32'h0000_1330);
        chk("R8 enable set", 32'(pll_mon_en), 32'h1);
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk("R9 zero write", v, 32'h0);
        chk("R8 enable clear", 32'(pll_mon_en), 32'h0);
        rd(4'h8, v); chk("R9 unmapped read", v, 32'h0);

        // R2 writing 0 to start has no effect
        repeat (3) @(posedge clk); #1;
        rd(4'h0, v); chk("R2 no self start", 32'(v[0]), 32'h0);

        // R3 R4 R5 measurement for every select code
        for (int s = 0; s < 4; s++) begin
            wr(4'h0, word(s, 3, 1'b0, 1'b1));
            wait_idle(n);
            chk("R3 busy length", 32'(n), 32'(WIN));
            rd(4'h4, v); chk($sformatf("R4 R5 count sel=%0d", s), v, 32'(exp_cnt[s]));
        end

        // R9 result word is read only
        wr(4'h4, 32'h0000_00FF);
        rd(4'h4, v); chk("R9 result write ignored", v, 32'(exp_cnt[3]));

        // R7 select frozen while busy, other fields live; R2 zero write ignored
        wr(4'h0, word(1, 3, 1'b0, 1'b1));
        repeat (5) @(posedge clk); #1;
        wr(4'h0, word(2, 0, 1'b1, 1'b0));
        rd(4'h0, v);
        chk("R7 sel held", 32'(v[5:4]), 32'h1);
        chk("R7 div updated", 32'(v[9:8]), 32'h0);
        chk("R7 enable updated", 32'(pll_mon_en), 32'h1);
        chk("R2 zero write keeps start", 32'(v[0]), 32'h1);
        wait_idle(n);
        rd(4'h4, v); chk("R7 count from held source", v, 32'd20);
        wr(4'h0, word(2, 0, 1'b0, 1'b0));
        rd(4'h0, v); chk("R7 sel accepted when idle", 32'(v[5:4]), 32'h2);

        // R6 divider sweep: rises of ref_clk_out over 64 fast periods
        for (int dv = 0; dv < 4; dv++) begin
            logic prev, cur;
            int rises;
            wr(4'h0, word(0, dv, 1'b0, 1'b0));
            repeat (8) @(posedge clk); #1;
            prev = ref_clk_out; rises = 0;
            for (int c = 0; c < 256; c++) begin
                @(posedge clk); #1;
                cur = ref_clk_out;
                if (cur && !prev) rises++;
                prev = cur;
            end
            chk($sformatf("R6 divide field=%0d", dv), 32'(rises), 32'(64 >> dv));
        end

        // R2 reset in the middle of a measurement
        wr(4'h0, word(0, 3, 1'b0, 1'b1));
        repeat (10) @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        rd(4'h0, v); chk("R2 reset clears start", v, 32'h0000_0300);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R3 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule